// File: doc/BRIEF.md
# Multi-Channel Line Code Violation Counter Bank

This block holds eight 16-bit counters, one per line channel, each advancing by one in every clock cycle in which that channel's violation pulse input is high. A processor reaches the bank through a small byte-wide register port. The channel is chosen indirectly: software writes a channel number into a select register, and every later action applies to that channel.

A control register carries three bits. A rising edge on the capture bit copies the live count into that channel's holding register. The clear bit zeroes the live count once it has stayed set for a minimum number of clock cycles. The byte-select bit picks the low or high half of the held value. The data register returns that half. Software therefore reads a frozen value in two bytes, and pulses that arrive between the two reads cannot split it.

Top module: `lcv_bank`

## Requirements
- R1: After reset, the select register, the control register and the read data all read 00h, and every counter and holding register is zero.
- R2: The register offsets are: 0 = channel select, with the channel number in bits 3:0; 1 = control, with bit 0 capture, bit 1 clear and bit 2 byte-select; 2 = data, which is read-only and ignores writes; 3 = reserved, which reads 00h. Offsets 0 and 1 read back what was written in their defined bits. `bus_rdata` takes its new value at the clock edge that samples `bus_rd`.
- R3: A channel's live counter increases by exactly one in each cycle in which its `viol_pulse` bit is high, and is unchanged otherwise.
- R4: A live counter that has reached FFFFh stays at FFFFh under further pulses.
- R5: A 0-to-1 change of control bit 0 copies the selected channel's live count, as it stood before that write's clock edge, into the channel's holding register. Writing 1 again while the bit is already 1 does not refresh the held value.
- R6: A data read returns held bits 7:0 when control bit 2 is 0 and held bits 15:8 when it is 1. The held value does not change with later pulses.
- R7: The selected counter is cleared only after control bit 1 has been 1 for `CLR_HOLD_CYC` consecutive cycles on the same channel. A shorter assertion leaves the count unchanged.
- R8: While the clear is in effect, the cleared counter stays 0 even when a pulse arrives in the same cycle. The counters of other channels keep counting.
- R9: A channel number of 8 to 15 is invalid. For an invalid channel, capture and clear change no counter and no holding register, and a data read returns 00h.
- R10: Each channel has its own holding register. A capture on one channel leaves the held values of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| viol_pulse | input | 8 | One violation pulse per channel, high for one count per cycle |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |

## Verification
A live counter that counts wrongly becomes visible at the first capture and read. The error then shows in one of the two bytes, so random pulse bursts are followed by full two-byte readouts of random channels. A holding register that refreshes when it should not, or a clear timer that fires early, shows up as a byte that differs from the bench's model on the next readout. The directed cases target these faults: the saturation edge, clears that are held too briefly, pulses that arrive during a clear, invalid channel numbers, and the persistence of held values across channels.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
  typedef enum logic [1:0] {
    REG_CHSEL = 2'd0,
    REG_CTRL  = 2'd1,
    REG_DATA  = 2'd2,
    REG_RSVD  = 2'd3
  } reg_sel_e;

  localparam int CTRL_W     = 3;
  localparam int CTRL_SNAP  = 0;
  localparam int CTRL_CLR   = 1;
  localparam int CTRL_HISEL = 2;
  localparam int BUS_W      = 8;
endpackage

// File: rtl/lcv_chan.sv
module lcv_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          viol,
  input  logic          clr,
  input  logic          snap,
  output logic [CW-1:0] live,
  output logic [CW-1:0] held
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  function automatic logic [CW-1:0] next_count(input logic [CW-1:0] cur,
                                                input logic inc, input logic wipe);
    if (wipe)                      return '0;
    else if (inc && cur != CNT_MAX) return cur + 1'b1;
    else                           return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live <= '0;
      held <= '0;
    end else begin
      live <= next_count(live, viol, clr);
      if (snap) held <= live;
    end
  end

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && viol && live != CNT_MAX) |=> live == $past(live) + 1'b1);
  a_r3_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !viol) |=> $stable(live));
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && live == CNT_MAX) |=> live == CNT_MAX);
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> live == '0);
  a_r5_snap_copy: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> held == $past(live));
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !snap |=> $stable(held));
endmodule

// File: rtl/lcv_clr_timer.sv
module lcv_clr_timer #(
  parameter int LIMIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic restart,
  output logic fire
);
  localparam int AW = $clog2(LIMIT + 1);
  localparam logic [AW-1:0] AGE_MAX = AW'(LIMIT);

  logic [AW-1:0] age;

  function automatic logic [AW-1:0] next_age(input logic [AW-1:0] cur,
                                             input logic held_on, input logic rs);
    if (!held_on || rs)       return '0;
    else if (cur != AGE_MAX)  return cur + 1'b1;
    else                      return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else        age <= next_age(age, req, restart);
  end

  assign fire = req && (age == AGE_MAX);

  a_r7_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
    age <= AGE_MAX);
  a_r7_age_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> age == '0);
  a_r7_fire_mature: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire) |-> $past(age) == AGE_MAX - 1'b1);
endmodule

// File: rtl/lcv_regs.sv
module lcv_regs
  import lcv_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int CW    = 16,
  parameter int CH_AW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [1:0]          bus_addr,
  input  logic [BUS_W-1:0]    bus_wdata,
  input  logic [NCH*CW-1:0]   held_flat,
  output logic [CH_AW-1:0]    ch_q,
  output logic                ch_valid,
  output logic                snap_evt,
  output logic                clr_req,
  output logic                ch_wr,
  output logic [BUS_W-1:0]    bus_rdata
);
  localparam logic [CH_AW:0] NCH_V = (CH_AW+1)'(NCH);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0]     held_sel;
  logic [BUS_W-1:0]  rd_next;
  logic              wr_ctrl;

  function automatic logic [BUS_W-1:0] pick_byte(input logic [CW-1:0] word,
                                                 input logic hi);
    logic [2*BUS_W-1:0] w;
    w = (2*BUS_W)'(word);
    return hi ? w[2*BUS_W-1:BUS_W] : w[BUS_W-1:0];
  endfunction

  assign ch_valid = {1'b0, ch_q} < NCH_V;
  assign wr_ctrl  = bus_wr && (bus_addr == REG_CTRL);
  assign ch_wr    = bus_wr && (bus_addr == REG_CHSEL);
  assign snap_evt = wr_ctrl && bus_wdata[CTRL_SNAP] && !ctrl_q[CTRL_SNAP] && ch_valid;
  assign clr_req  = ctrl_q[CTRL_CLR] && ch_valid;

  always_comb begin
    held_sel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (ch_q == CH_AW'(i)) held_sel = held_flat[i*CW +: CW];
    end
  end

  always_comb begin
    case (reg_sel_e'(bus_addr))
      REG_CHSEL: rd_next = BUS_W'(ch_q);
      REG_CTRL:  rd_next = BUS_W'(ctrl_q);
      REG_DATA:  rd_next = ch_valid ? pick_byte(held_sel, ctrl_q[CTRL_HISEL]) : '0;
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q      <= '0;
      ctrl_q    <= '0;
      bus_rdata <= '0;
    end else begin
      if (ch_wr)   ch_q   <= bus_wdata[CH_AW-1:0];
      if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (bus_rd)  bus_rdata <= rd_next;
    end
  end

  a_r2_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  a_r9_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_DATA && !ch_valid) |=> bus_rdata == '0);
  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_RSVD) |=> bus_rdata == '0);
  a_r5_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    snap_evt |=> ctrl_q[CTRL_SNAP]);
endmodule

// File: rtl/lcv_bank.sv
module lcv_bank
  import lcv_pkg::*;
#(
  parameter int NCH          = 8,
  parameter int CW           = 16,
  parameter int CH_AW        = 4,
  parameter int CLR_HOLD_CYC = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   viol_pulse,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata
);
  logic [CH_AW-1:0]  ch_q;
  logic              ch_valid;
  logic              snap_evt;
  logic              clr_req;
  logic              ch_wr;
  logic              clr_fire;
  logic [NCH-1:0]    snap_vec;
  logic [NCH-1:0]    clr_vec;
  logic [NCH*CW-1:0] held_flat;
  logic [NCH*CW-1:0] live_flat;

  lcv_regs #(.NCH(NCH), .CW(CW), .CH_AW(CH_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .held_flat(held_flat),
    .ch_q(ch_q), .ch_valid(ch_valid), .snap_evt(snap_evt),
    .clr_req(clr_req), .ch_wr(ch_wr), .bus_rdata(bus_rdata)
  );

  lcv_clr_timer #(.LIMIT(CLR_HOLD_CYC)) u_clr (
    .clk(clk), .rst_n(rst_n), .req(clr_req), .restart(ch_wr), .fire(clr_fire)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign snap_vec[g] = snap_evt && (ch_q == CH_AW'(g));
    assign clr_vec[g]  = clr_fire && (ch_q == CH_AW'(g));
    lcv_chan #(.CW(CW)) u_chan (
      .clk(clk), .rst_n(rst_n), .viol(viol_pulse[g]),
      .clr(clr_vec[g]), .snap(snap_vec[g]),
      .live(live_flat[g*CW +: CW]), .held(held_flat[g*CW +: CW])
    );
  end

  a_r10_one_snap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snap_vec));
  a_r9_no_clear_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_valid |-> clr_vec == '0);
  a_r9_no_snap_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_valid |-> snap_vec == '0);
  a_r7_clear_needs_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vec != '0) |-> clr_req);
endmodule

// File: tb/tb_lcv_bank.sv
module tb_lcv_bank;
  localparam int NCH = 8;
  localparam int CLR = 100;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] viol_pulse = '0;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [1:0]     bus_addr = '0;
  logic [7:0]     bus_wdata = '0;
  logic [7:0]     bus_rdata;

  int total = 0;
  int fails = 0;
  logic [15:0] model [NCH];

  lcv_bank #(.NCH(NCH), .CW(16), .CH_AW(4), .CLR_HOLD_CYC(CLR)) dut (
    .clk(clk), .rst_n(rst_n), .viol_pulse(viol_pulse), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] sat_add(input logic [15:0] v);
    return (v == 16'hFFFF) ? v : v + 16'd1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_cycles(input logic [NCH-1:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      viol_pulse = m;
      @(posedge clk);
      for (int c = 0; c < NCH; c++) if (m[c]) model[c] = sat_add(model[c]);
    end
    @(negedge clk);
    viol_pulse = '0;
  endtask

  task automatic read_held(input int ch, output logic [15:0] v);
    logic [7:0] lo, hi;
    bus_write(2'd0, 8'(ch));
    bus_write(2'd1, 8'h00);
    bus_read(2'd2, lo);
    bus_write(2'd1, 8'h04);
    bus_read(2'd2, hi);
    bus_write(2'd1, 8'h00);
    v = {hi, lo};
  endtask

  task automatic snap_read(input int ch, output logic [15:0] v);
    bus_write(2'd0, 8'(ch));
    bus_write(2'd1, 8'h00);
    bus_write(2'd1, 8'h01);
    read_held(ch, v);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] v, a2;
    void'($urandom(32'd20250611));
    for (int c = 0; c < NCH; c++) model[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 rdata", 32'(bus_rdata), 0);
    bus_read(2'd0, b); chk("R1 chsel", 32'(b), 0);
    bus_read(2'd1, b); chk("R1 ctrl", 32'(b), 0);
    bus_read(2'd2, b); chk("R1 data", 32'(b), 0);

    // R2 map and readback
    bus_write(2'd0, 8'h05); bus_read(2'd0, b); chk("R2 chsel readback", 32'(b), 5);
    bus_write(2'd1, 8'h04); bus_read(2'd1, b); chk("R2 ctrl readback", 32'(b), 4);
    bus_write(2'd2, 8'hAB); bus_read(2'd1, b); chk("R2 data write ignored", 32'(b), 4);
    bus_read(2'd3, b); chk("R2 reserved", 32'(b), 0);
    bus_write(2'd1, 8'h00);

    // R3 / R6 random bursts and readouts
    for (int it = 0; it < 120; it++) begin
      int ch;
      pulse_cycles(NCH'($urandom), $urandom_range(1, 40));
      ch = $urandom_range(0, NCH - 1);
      snap_read(ch, v);
      chk("R3 R6 random readout", 32'(v), 32'(model[ch]));
    end

    // R5 holding bit high does not refresh
    snap_read(4, v);
    bus_write(2'd0, 8'd4);
    bus_write(2'd1, 8'h01);
    a2 = model[4];
    pulse_cycles(8'h10, 6);
    bus_write(2'd1, 8'h01);
    bus_read(2'd2, b);
    chk("R5 no refresh while high", 32'(b), 32'(a2[7:0]));
    bus_write(2'd1, 8'h00);
    bus_write(2'd1, 8'h01);
    bus_read(2'd2, b);
    chk("R5 new edge captures", 32'(b), 32'(model[4][7:0]));
    bus_write(2'd1, 8'h00);

    // R10 held value persists across channels
    pulse_cycles(8'hFF, 7);
    snap_read(2, a2);
    pulse_cycles(8'hFF, 9);
    snap_read(3, v);
    chk("R10 other channel capture", 32'(v), 32'(model[3]));
    read_held(2, v);
    chk("R10 held kept", 32'(v), 32'(a2));

    // R4 saturation
    pulse_cycles(8'h80, 65540);
    snap_read(7, v);
    chk("R4 saturate", 32'(v), 32'hFFFF);

    // R7 short clear has no effect
    pulse_cycles(8'h02, 3);
    bus_write(2'd0, 8'd1);
    bus_write(2'd1, 8'h02);
    repeat (CLR / 2) @(negedge clk);
    bus_write(2'd1, 8'h00);
    snap_read(1, v);
    chk("R7 short clear ignored", 32'(v), 32'(model[1]));

    // R7 / R8 full clear, pulses during clear
    bus_write(2'd0, 8'd7);
    bus_write(2'd1, 8'h02);
    repeat (CLR + 5) @(negedge clk);
    pulse_cycles(8'hFF, 4);
    model[7] = '0;
    bus_write(2'd1, 8'h00);
    snap_read(7, v);
    chk("R7 R8 cleared under pulses", 32'(v), 0);
    snap_read(6, v);
    chk("R8 neighbour counted", 32'(v), 32'(model[6]));

    // R9 invalid channel
    bus_write(2'd0, 8'd9);
    bus_read(2'd0, b); chk("R9 chsel 9 readback", 32'(b), 9);
    bus_write(2'd1, 8'h01);
    bus_read(2'd2, b); chk("R9 data reads zero", 32'(b), 0);
    bus_write(2'd1, 8'h00);
    bus_write(2'd1, 8'h02);
    repeat (CLR + 5) @(negedge clk);
    bus_write(2'd1, 8'h00);
    for (int c = 0; c < NCH; c++) begin
      snap_read(c, v);
      chk("R9 counters untouched", 32'(v), 32'(model[c]));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule